// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire station management bus used between Ethernet MACs and PHYs. Software configures a clock divider and a frame format, then launches a bus transaction by writing one of three trigger registers. The block runs the serial frame bit by bit. It generates the management clock and drives the data line toward an external tristate pad through a separate output-enable. During read turnaround and data, it samples the returned line.

Both the short frame format (start bits `01`, register addressing) and the extended format (start bits `00`, device addressing through a separate address frame) are served from one set of four 32-bit registers. Software selects the register with a 2-bit word index: 0 is configuration/status, 1 is control, 2 is data and 3 is address. Each transaction sets a busy flag, which software polls in configuration bit 0 or data bit 31. When it clears, a read result sits in the low half of the data register. The configuration register also flags a read that nobody answered.

The register port carries no back-pressure. A write lands in the cycle it is presented. A trigger that arrives while a frame is running is dropped rather than stalled, so software must poll busy before issuing the next trigger. Register reads are combinational on the read index.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads zero, `busy` is 0, `mdc` is low and `mdio_oe` is low.
- R2: Configuration bit 6 selects the extended format (1) or the short format (0). Bits 15:8 hold a divider field N, and each half of the clock period lasts N cycles (N=0 acts as 1). Both fields read back as written. `mdc` stays low whenever no frame is active.
- R3: In short format, a data-register write starts a write frame: 32 ones, then `01`, `01`, the 5-bit port from control bits 9:5, the 5-bit register from control bits 4:0, turnaround `10`, then the 16 data bits. All fields are sent MSB first.
- R4: A control write with bit 15 set starts a read frame. The short-format opcode is `10`. The master releases the line (`mdio_oe` low) from the first turnaround bit to the end of the frame. It stores the 16 bits returned, MSB first, in data bits 15:0.
- R5: In extended format, an address-register write starts an address frame: `00`, opcode `00`, port, device, `10`, then the 16-bit address. In short format, an address write only stores the value and starts no frame.
- R6: Extended-format opcodes are `01` for write and `11` for read. A read with control bit 14 set uses opcode `10` (post-increment).
- R7: With control bit 10 set, the preamble is omitted, the frame is 32 clock periods long, and it starts directly with the start bits.
- R8: Configuration bit 1 is set when the second turnaround bit of a read is sampled as 1. It is cleared when the next frame starts.
- R9: `busy`, configuration bit 0 and data bit 31 rise on the trigger edge. They stay high for exactly (bits × 2 × N) cycles, where bits is 64 with the preamble and 32 without it.
- R10: A write to control, data or address while busy changes no register and neither alters nor restarts the running frame.
- R11: `mdio_o` changes only on a falling edge of `mdc`. Returned bits are sampled on rising edges.
- R12: `mdio_oe` is low whenever no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Word index of the register written |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Word index of the register read |
| reg_rdata | output | 32 | Read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data toward the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Serial data from the pad |
| busy | output | 1 | Frame in progress |

## Verification
The hardest condition to reach is a read that nobody answers, followed by the proof that the error flag clears on the next frame. The bench's PHY responder has a mute switch, so the pulled-up line returns a 1 in the second turnaround slot and ones for the data. A write frame is then issued and the flag is read back. A second hard case is a trigger that lands mid-frame. The stimulus fires data, control and address writes during a long read, then checks that the scoreboard saw exactly one frame with unchanged fields and that the registers still hold their earlier values.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned TA_FIRST   = 14;
  localparam int unsigned TA_SECOND  = 15;

  localparam logic [1:0] SEL_CFG = 2'd0;
  localparam logic [1:0] SEL_CTL = 2'd1;
  localparam logic [1:0] SEL_DAT = 2'd2;
  localparam logic [1:0] SEL_ADR = 2'd3;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_READ  = 2'd1,
    KIND_ADDR  = 2'd2
  } kind_e;

  typedef struct packed {
    logic        ext;
    kind_e       kind;
    logic        inc;
    logic        no_pre;
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [15:0] data;
  } req_t;

  // Serialised frame body, MSB leaves first.
  function automatic logic [FRAME_BITS-1:0] pack_frame(input req_t r);
    logic [1:0]  st;
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] d;
    st = r.ext ? 2'b00 : 2'b01;
    ta = 2'b10;
    d  = r.data;
    if (r.kind == KIND_READ) begin
      if (r.ext) op = r.inc ? 2'b10 : 2'b11;
      else       op = 2'b10;
      ta = 2'b11;
      d  = 16'hFFFF;
    end else if (r.kind == KIND_WRITE) begin
      op = 2'b01;
    end else begin
      op = 2'b00;
    end
    return {st, op, r.port, r.dev, ta, d};
  endfunction
endpackage

// File: rtl/mdio_mdc_timer.sv
`timescale 1ns/1ps
module mdio_mdc_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  // half is never zero while run is high (engine clamps it)
  assign wrap = run && (cnt_q == half - 1'b1);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  req_t             req,
  input  logic [DIV_W-1:0] div_field,
  input  logic             mdi,
  output logic             busy,
  output logic             mdc,
  output logic             mdo,
  output logic             moe,
  output logic             rd_done,
  output logic [15:0]      rd_data,
  output logic             rd_err
);
  localparam int PC_W = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
  localparam int BC_W = $clog2(FRAME_BITS);
  localparam logic [PC_W-1:0] PRE_LAST = PC_W'(PRE_LEN - 1);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(FRAME_BITS - 1);
  localparam logic [BC_W-1:0] TA1      = BC_W'(TA_FIRST);
  localparam logic [BC_W-1:0] TA2      = BC_W'(TA_SECOND);

  logic                  busy_q, pre_q, rd_q, err_q;
  logic [PC_W-1:0]       pcnt_q;
  logic [BC_W-1:0]       bcnt_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [15:0]           rx_q;
  logic [DIV_W-1:0]      half_q;
  logic                  rise, fall;

  mdio_mdc_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .half (half_q),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  assign busy    = busy_q;
  assign mdo     = pre_q ? 1'b1 : sh_q[FRAME_BITS-1];
  assign moe     = busy_q && !(rd_q && !pre_q && (bcnt_q >= TA1));
  assign rd_done = fall && busy_q && !pre_q && rd_q && (bcnt_q == BIT_LAST);
  assign rd_data = rx_q;
  assign rd_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pre_q  <= 1'b0;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      pcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      half_q <= DIV_W'(1);
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        pre_q  <= !req.no_pre;
        rd_q   <= (req.kind == KIND_READ);
        err_q  <= 1'b0;
        pcnt_q <= '0;
        bcnt_q <= '0;
        sh_q   <= pack_frame(req);
        rx_q   <= '0;
        half_q <= (div_field == '0) ? DIV_W'(1) : div_field;
      end
    end else begin
      if (rise && rd_q && !pre_q) begin
        if (bcnt_q == TA2) err_q <= mdi;
        if (bcnt_q > TA2)  rx_q  <= {rx_q[14:0], mdi};
      end
      if (fall) begin
        if (pre_q) begin
          if (pcnt_q == PRE_LAST) pre_q <= 1'b0;
          else                    pcnt_q <= pcnt_q + 1'b1;
        end else if (bcnt_q == BIT_LAST) begin
          busy_q <= 1'b0;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
          sh_q   <= {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_csr.sv
`timescale 1ns/1ps
module mdio_csr
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       waddr,
  input  logic [31:0]      wdata,
  input  logic [1:0]       raddr,
  output logic [31:0]      rdata,
  input  logic             busy,
  input  logic             rd_done,
  input  logic [15:0]      rd_data,
  input  logic             rd_err,
  output logic             start,
  output req_t             req,
  output logic [DIV_W-1:0] div_field
);
  logic             ext_q;
  logic [DIV_W-1:0] div_q;
  logic [4:0]       dev_q, port_q;
  logic             nopre_q, scan_q, inc_q, rdcmd_q;
  logic [15:0]      data_q, addr_q;
  logic             free_wr;

  assign free_wr   = wr && !busy;
  assign div_field = div_q;

  always_comb begin
    start       = 1'b0;
    req.ext     = ext_q;
    req.kind    = KIND_WRITE;
    req.inc     = inc_q;
    req.no_pre  = nopre_q;
    req.port    = port_q;
    req.dev     = dev_q;
    req.data    = wdata[15:0];
    if (free_wr) begin
      if (waddr == SEL_CTL && wdata[15]) begin
        start      = 1'b1;
        req.kind   = KIND_READ;
        req.inc    = wdata[14];
        req.no_pre = wdata[10];
        req.port   = wdata[9:5];
        req.dev    = wdata[4:0];
      end else if (waddr == SEL_DAT) begin
        start    = 1'b1;
        req.kind = KIND_WRITE;
      end else if (waddr == SEL_ADR && ext_q) begin
        start    = 1'b1;
        req.kind = KIND_ADDR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      div_q   <= '0;
      dev_q   <= '0;
      port_q  <= '0;
      nopre_q <= 1'b0;
      scan_q  <= 1'b0;
      inc_q   <= 1'b0;
      rdcmd_q <= 1'b0;
      data_q  <= '0;
      addr_q  <= '0;
    end else begin
      if (wr && waddr == SEL_CFG) begin
        ext_q <= wdata[6];
        div_q <= DIV_W'(wdata[15:8]);
      end
      if (free_wr && waddr == SEL_CTL) begin
        dev_q   <= wdata[4:0];
        port_q  <= wdata[9:5];
        nopre_q <= wdata[10];
        scan_q  <= wdata[11];
        inc_q   <= wdata[14];
        rdcmd_q <= wdata[15];
      end
      if (free_wr && waddr == SEL_DAT) data_q <= wdata[15:0];
      else if (rd_done)                data_q <= rd_data;
      if (free_wr && waddr == SEL_ADR) addr_q <= wdata[15:0];
    end
  end

  always_comb begin
    unique case (raddr)
      SEL_CFG: rdata = {16'h0, 8'(div_q), 1'b0, ext_q, 4'h0, rd_err, busy};
      SEL_CTL: rdata = {16'h0, rdcmd_q, inc_q, 2'b00, scan_q, nopre_q, port_q, dev_q};
      SEL_DAT: rdata = {busy, 15'h0, data_q};
      default: rdata = {16'h0, addr_q};
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        busy
);
  logic             start_w, rd_done_w, rd_err_w;
  logic [15:0]      rd_data_w;
  logic [DIV_W-1:0] div_w;
  req_t             req_w;

  mdio_csr #(.DIV_W(DIV_W)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .waddr    (reg_waddr),
    .wdata    (reg_wdata),
    .raddr    (reg_raddr),
    .rdata    (reg_rdata),
    .busy     (busy),
    .rd_done  (rd_done_w),
    .rd_data  (rd_data_w),
    .rd_err   (rd_err_w),
    .start    (start_w),
    .req      (req_w),
    .div_field(div_w)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .req      (req_w),
    .div_field(div_w),
    .mdi      (mdio_i),
    .busy     (busy),
    .mdc      (mdc),
    .mdo      (mdio_o),
    .moe      (mdio_oe),
    .rd_done  (rd_done_w),
    .rd_data  (rd_data_w),
    .rd_err   (rd_err_w)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic reg_wr,
  input logic rd_err
);
  assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_oe_idle_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_out_moves_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  assert_err_only_at_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(busy) && !$rose(mdc)) |-> $stable(rd_err));

  assert_busy_needs_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .mdc    (mdc),
  .mdio_o (mdio_o),
  .mdio_oe(mdio_oe),
  .reg_wr (reg_wr),
  .rd_err (rd_err_w)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [1:0]  reg_raddr = 2'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i, busy;

  logic        phy_oe = 1'b0;
  logic        phy_val = 1'b1;
  logic        phy_mute = 1'b0;
  logic [15:0] phy_rdval = 16'h0000;

  int n_chk = 0;
  int n_bad = 0;
  int contention = 0;
  int edge_bad = 0;
  bit finished = 0;

  logic [29:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

  mdio_mgmt_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 100000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic expect_frame(input string req, input logic [1:0] st, input logic [1:0] op,
                              input logic [4:0] pa, input logic [4:0] da, input logic [15:0] d);
    exp_q.push_back({st, op, pa, da, d});
    tag_q.push_back(req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // PHY responder and scoreboard monitor
  initial begin
    logic [13:0] hdr;
    logic [17:0] tail;
    logic [15:0] got;
    logic [29:0] exp_item;
    logic        rdf;
    string       tag;
    forever begin
      do @(posedge mdc); while (mdio_i !== 1'b0);
      hdr[13] = 1'b0;
      for (int i = 12; i >= 0; i--) begin
        @(posedge mdc);
        hdr[i] = mdio_i;
      end
      rdf = (hdr[13:12] == 2'b01 && hdr[11:10] == 2'b10) ||
            (hdr[13:12] == 2'b00 && hdr[11]);
      if (rdf) begin
        @(negedge mdc);
        @(negedge mdc);
        if (!phy_mute) begin phy_oe = 1'b1; phy_val = 1'b0; end
        for (int i = 15; i >= 0; i--) begin
          @(negedge mdc);
          phy_val = phy_rdval[i];
        end
        @(negedge mdc);
        phy_oe = 1'b0; phy_val = 1'b1;
        got = phy_mute ? 16'hFFFF : phy_rdval;
      end else begin
        for (int i = 17; i >= 0; i--) begin
          @(posedge mdc);
          tail[i] = mdio_i;
        end
        got = tail[15:0];
      end
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 unexpected frame actual=%h expected=none", {hdr, got});
      end else begin
        exp_item = exp_q.pop_front();
        tag = tag_q.pop_front();
        check(tag, 32'({hdr, got}), 32'(exp_item));
      end
    end
  end

  // R4 contention and R11 edge discipline monitor
  initial begin
    logic pm, po, pb;
    pm = 1'b0; po = 1'b1; pb = 1'b0;
    forever begin
      @(negedge clk);
      if (mdio_oe && phy_oe) contention++;
      if (busy && pb && (mdio_o !== po) && !(pm && !mdc)) edge_bad++;
      pm = mdc; po = mdio_o; pb = busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd0, r); check("R1 cfg", r, 32'h0);
    reg_read(2'd1, r); check("R1 ctl", r, 32'h0);
    reg_read(2'd2, r); check("R1 data", r, 32'h0);
    check("R1 mdc", 32'(mdc), 32'h0);
    check("R12 oe", 32'(mdio_oe), 32'h0);

    // R2 divider field 2, short format
    reg_write(2'd0, 32'h0000_0200);
    reg_read(2'd0, r); check("R2 cfg readback", r, 32'h0000_0200);

    // R3 short write frame, R9 duration 64*2*2
    reg_write(2'd1, 32'h0000_00B1);
    expect_frame("R3 c22 write", 2'b01, 2'b01, 5'd5, 5'h11, 16'hA5C3);
    reg_write(2'd2, 32'h0000_A5C3);
    wait_idle(cyc);
    check("R9 busy length", 32'(cyc), 32'd256);
    check("R12 oe after", 32'(mdio_oe), 32'h0);

    // R4 short read, R9 busy flags, R10 writes while busy
    phy_rdval = 16'h3C5A;
    expect_frame("R4 c22 read", 2'b01, 2'b10, 5'd3, 5'd2, 16'h3C5A);
    reg_write(2'd1, 32'h0000_8062);
    reg_read(2'd0, r); check("R9 cfg busy bit", 32'(r[0]), 32'h1);
    reg_read(2'd2, r); check("R9 data busy bit", 32'(r[31]), 32'h1);
    reg_write(2'd2, 32'h0000_1234);
    reg_write(2'd1, 32'h0000_8124);
    reg_write(2'd3, 32'h0000_7777);
    wait_idle(cyc);
    reg_read(2'd2, r); check("R4 read data", r, 32'h0000_3C5A);
    reg_read(2'd0, r); check("R8 no error", r, 32'h0000_0200);
    reg_read(2'd1, r); check("R10 ctl kept", r, 32'h0000_8062);
    reg_read(2'd3, r); check("R10 addr kept", r, 32'h0);

    // R7 no preamble, divider 1: 32*2*1
    reg_write(2'd0, 32'h0000_0100);
    reg_write(2'd1, 32'h0000_04E9);
    expect_frame("R7 no preamble", 2'b01, 2'b01, 5'd7, 5'd9, 16'h0F0F);
    reg_write(2'd2, 32'h0000_0F0F);
    wait_idle(cyc);
    check("R7 busy length", 32'(cyc), 32'd64);

    // R5 / R6 extended format
    reg_write(2'd0, 32'h0000_0140);
    reg_read(2'd0, r); check("R2 ext bit", r, 32'h0000_0140);
    reg_write(2'd1, 32'h0000_03FE);
    expect_frame("R5 c45 address", 2'b00, 2'b00, 5'h1F, 5'h1E, 16'hBEEF);
    reg_write(2'd3, 32'h0000_BEEF);
    wait_idle(cyc);
    check("R9 c45 busy length", 32'(cyc), 32'd128);
    expect_frame("R6 c45 write", 2'b00, 2'b01, 5'h1F, 5'h1E, 16'h1357);
    reg_write(2'd2, 32'h0000_1357);
    wait_idle(cyc);
    phy_rdval = 16'h6A01;
    expect_frame("R6 c45 read", 2'b00, 2'b11, 5'h1F, 5'h1E, 16'h6A01);
    reg_write(2'd1, 32'h0000_83FE);
    wait_idle(cyc);
    reg_read(2'd2, r); check("R6 c45 read data", r, 32'h0000_6A01);
    phy_rdval = 16'h80F7;
    expect_frame("R6 c45 read inc", 2'b00, 2'b10, 5'h1F, 5'h1E, 16'h80F7);
    reg_write(2'd1, 32'h0000_C3FE);
    wait_idle(cyc);
    reg_read(2'd2, r); check("R6 inc read data", r, 32'h0000_80F7);

    // R5 short format address write starts nothing
    reg_write(2'd0, 32'h0000_0100);
    reg_write(2'd3, 32'h0000_4444);
    check("R5 no frame busy", 32'(busy), 32'h0);
    reg_read(2'd3, r); check("R5 addr stored", r, 32'h0000_4444);

    // R8 unanswered read, then cleared by next frame
    phy_mute = 1'b1;
    expect_frame("R8 muted read", 2'b01, 2'b10, 5'd3, 5'd2, 16'hFFFF);
    reg_write(2'd1, 32'h0000_8062);
    wait_idle(cyc);
    reg_read(2'd0, r); check("R8 error set", r, 32'h0000_0102);
    reg_read(2'd2, r); check("R8 data ones", r, 32'h0000_FFFF);
    phy_mute = 1'b0;
    reg_write(2'd1, 32'h0000_0062);
    expect_frame("R8 clearing write", 2'b01, 2'b01, 5'd3, 5'd2, 16'h0001);
    reg_write(2'd2, 32'h0000_0001);
    wait_idle(cyc);
    reg_read(2'd0, r); check("R8 error cleared", r, 32'h0000_0100);

    repeat (10) @(negedge clk);
    check("R10 all frames seen", 32'(exp_q.size()), 32'd0);
    check("R4 no line contention", 32'(contention), 32'd0);
    check("R11 output edge", 32'(edge_bad), 32'd0);
    check("R2 mdc idle", 32'(mdc), 32'h0);

    finished = 1;
    summary();
    $finish;
  end
endmodule